// File: doc/BRIEF.md
# Breakpoint Address Match Table

This block holds a short, ordered list of breakpoints. Each entry pairs an instruction address with a two-bit breakpoint kind. Commands reach the block on a valid/ready stream and come in two forms. An insert appends an entry at the end of the list. A removal looks for an entry whose address and kind both equal the request, deletes it, and closes the gap so the list stays contiguous. Each command yields exactly one response, carried on a second valid/ready stream as a success bit.

A separate combinational port compares a fetch address against every live entry. It returns the kind of the lowest-numbered entry that matches, or zero when nothing matches. Whenever an insert or a removal succeeds, the block drives a one-cycle invalidate strobe with the affected address, so a downstream translation cache can drop any stale copy of that address.

Closing the gap takes one cycle for each entry that moves down. The command side stays not-ready until the response for the current command has been accepted. The response stream honours back-pressure: once `rsp_valid` rises, it and `rsp_ok` hold steady until `rsp_ready` is seen high at a clock edge.

Top module: `bkpt_table`

## Requirements
- R1: After reset the table is empty, `cmd_ready` is 1, `rsp_valid` and `inval_valid` are 0, and `fetch_type` is 0 for any address.
- R2: An insert (`cmd_op` = 0) with a non-zero kind, accepted while fewer than DEPTH entries are held, stores the entry in slot [count], increments the count and responds with `rsp_ok` = 1. `rsp_valid` is first visible in the cycle after the accepting edge.
- R3: An insert accepted while DEPTH entries are held is rejected with `rsp_ok` = 0. The table is left unchanged and no invalidate strobe is produced.
- R4: An insert whose kind is 0 (the reserved "no breakpoint" code) is rejected with `rsp_ok` = 0 and leaves the table unchanged.
- R5: A removal (`cmd_op` = 1) succeeds only if some live entry matches both the address and the kind. A miss responds `rsp_ok` = 0, changes nothing and produces no strobe.
- R6: A successful removal deletes the lowest-numbered entry that matches both fields. Every later entry moves down one slot with its relative order kept, the count decrements, and the response has `rsp_ok` = 1.
- R7: Removing slot k from a table of n entries takes n-1-k compaction cycles. `rsp_valid` becomes visible n-k cycles after the accepting edge, and `cmd_ready` stays low throughout.
- R8: `fetch_type` combinationally returns the kind of the lowest-numbered live entry whose address equals `fetch_addr`, or 0 if there is no such entry.
- R9: Every successful insert or removal raises `inval_valid` for exactly one cycle, with `inval_addr` equal to the command address. The strobe appears in the first cycle of `rsp_valid`. Rejected commands never raise it.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid` and `rsp_ok` hold their values. `cmd_ready` is 0 whenever a response is pending or compaction is running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted at this edge when valid |
| cmd_op | input | 1 | 0 = insert, 1 = removal |
| cmd_addr | input | ADDR_W | Breakpoint address |
| cmd_type | input | 2 | Breakpoint kind (0 reserved) |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumed at this edge when valid |
| rsp_ok | output | 1 | 1 = command succeeded |
| fetch_addr | input | ADDR_W | Address to look up |
| fetch_type | output | 2 | Kind of first matching entry, 0 if none |
| inval_valid | output | 1 | One-cycle invalidate strobe |
| inval_addr | output | ADDR_W | Address to invalidate |

## Verification
The embedded properties assume that the stream inputs obey the handshake rules and that reset is applied before the first command. They also rely on the controller driving the compaction index only while a live entry sits above it. The bench drives every command at the falling edge and holds it until `cmd_ready` is seen high. It toggles `rsp_ready` with a pseudo-random pattern, so responses are stalled for varying spans. `fetch_addr` is only changed and read while the table is idle, which keeps lookups away from the transient duplicate entries that appear during compaction.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int TYPE_W = 2;
  localparam logic [TYPE_W-1:0] TYPE_NONE = '0;

  typedef enum logic {
    OP_INSERT = 1'b0,
    OP_DELETE = 1'b1
  } bkpt_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_RESP
  } bkpt_state_e;
endpackage

// File: rtl/bkpt_store.sv
module bkpt_store
  import bkpt_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           app_en,
  input  logic [ADDR_W-1:0]              app_addr,
  input  logic [TYPE_W-1:0]              app_type,
  input  logic                           mv_en,
  input  logic [IDX_W-1:0]               mv_idx,
  input  logic                           drop_en,
  output logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
  output logic [DEPTH-1:0][TYPE_W-1:0]   slot_type,
  output logic [DEPTH-1:0]               slot_live,
  output logic [CNT_W-1:0]               count
);

  // Slot i takes an append when it is the first free slot, or its upper
  // neighbour's contents during a compaction step aimed at it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_addr <= '0;
      slot_type <= '0;
      count     <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (app_en && count == CNT_W'(i)) begin
          slot_addr[i] <= app_addr;
          slot_type[i] <= app_type;
        end else if (mv_en && mv_idx == IDX_W'(i) && i < DEPTH - 1) begin
          slot_addr[i] <= slot_addr[(i + 1) % DEPTH];
          slot_type[i] <= slot_type[(i + 1) % DEPTH];
        end
      end
      if (app_en)
        count <= count + CNT_W'(1);
      else if (drop_en)
        count <= count - CNT_W'(1);
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_live
    assign slot_live[g] = CNT_W'(g) < count;
  end

  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R3
  AST_APPEND_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    app_en |-> count < CNT_W'(DEPTH)); // R3
  AST_APPEND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    app_en |=> count == $past(count) + CNT_W'(1)); // R2
  AST_DROP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_en |-> count != '0); // R6
  AST_NO_APPEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(app_en && (drop_en || mv_en))); // R7

endmodule

// File: rtl/bkpt_match.sv
module bkpt_match
  import bkpt_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int ADDR_W   = 32,
  parameter bit USE_TYPE = 1'b1,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0]              key_addr,
  input  logic [TYPE_W-1:0]              key_type,
  input  logic [DEPTH-1:0][ADDR_W-1:0]   slot_addr,
  input  logic [DEPTH-1:0][TYPE_W-1:0]   slot_type,
  input  logic [DEPTH-1:0]               slot_live,
  output logic                           hit,
  output logic [IDX_W-1:0]               hit_idx
);

  logic [DEPTH-1:0] eq;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = slot_live[g] && (slot_addr[g] == key_addr) &&
                   (!USE_TYPE || (slot_type[g] == key_type));
  end

  // Priority toward the lowest slot: scan downward, last hit wins.
  always_comb begin
    hit     = |eq;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [TYPE_W-1:0] cmd_type,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  output logic              inval_valid,
  output logic [ADDR_W-1:0] inval_addr,
  input  logic [CNT_W-1:0]  count,
  input  logic              del_hit,
  input  logic [IDX_W-1:0]  del_idx,
  output logic              app_en,
  output logic              mv_en,
  output logic [IDX_W-1:0]  mv_idx,
  output logic              drop_en
);

  bkpt_state_e       state;
  logic [IDX_W-1:0]  idx_q;
  logic              ok_q;
  logic              inval_q;
  logic [ADDR_W-1:0] iaddr_q;

  logic             accept, ins_go, del_go, del_tail, shift_done;
  logic [CNT_W-1:0] last_idx;

  assign cmd_ready  = (state == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign last_idx   = count - CNT_W'(1);
  assign ins_go     = accept && cmd_op == OP_INSERT && count < CNT_W'(DEPTH) &&
                      cmd_type != TYPE_NONE;
  assign del_go     = accept && cmd_op == OP_DELETE && del_hit;
  assign del_tail   = del_go && (CNT_W'(del_idx) == last_idx);
  assign shift_done = (state == ST_SHIFT) &&
                      (CNT_W'(idx_q) + CNT_W'(1) == last_idx);

  assign app_en  = ins_go;
  assign mv_en   = (state == ST_SHIFT);
  assign mv_idx  = idx_q;
  assign drop_en = del_tail || shift_done;

  assign rsp_valid   = (state == ST_RESP);
  assign rsp_ok      = ok_q;
  assign inval_valid = inval_q;
  assign inval_addr  = iaddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      idx_q   <= '0;
      ok_q    <= 1'b0;
      inval_q <= 1'b0;
      iaddr_q <= '0;
    end else begin
      inval_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            iaddr_q <= cmd_addr;
            if (del_go && !del_tail) begin
              state <= ST_SHIFT;
              idx_q <= del_idx;
            end else begin
              state   <= ST_RESP;
              ok_q    <= ins_go || del_go;
              inval_q <= ins_go || del_go;
            end
          end
        end
        ST_SHIFT: begin
          idx_q <= idx_q + IDX_W'(1);
          if (shift_done) begin
            state   <= ST_RESP;
            ok_q    <= 1'b1;
            inval_q <= 1'b1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok)); // R10
  AST_INVAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |=> !inval_valid); // R9
  AST_INVAL_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    inval_valid |-> rsp_valid && rsp_ok); // R9
  AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_en |-> CNT_W'(mv_idx) + CNT_W'(2) <= count); // R7
  AST_FULL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_INSERT && count == CNT_W'(DEPTH)
    |=> rsp_valid && !rsp_ok && !inval_valid); // R3
  AST_ZERO_KIND_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_INSERT && cmd_type == TYPE_NONE
    |=> rsp_valid && !rsp_ok); // R4
  AST_DEL_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == OP_DELETE && !del_hit
    |=> rsp_valid && !rsp_ok && !inval_valid); // R5

endmodule

// File: rtl/bkpt_table.sv
module bkpt_table
  import bkpt_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [1:0]        cmd_type,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [1:0]        fetch_type,
  output logic              inval_valid,
  output logic [ADDR_W-1:0] inval_addr
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
  logic [DEPTH-1:0][TYPE_W-1:0] slot_type;
  logic [DEPTH-1:0]             slot_live;
  logic [CNT_W-1:0]             count;
  logic                         app_en, mv_en, drop_en;
  logic [IDX_W-1:0]             mv_idx;
  logic                         del_hit, look_hit;
  logic [IDX_W-1:0]             del_idx, look_idx;

  bkpt_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .app_en(app_en), .app_addr(cmd_addr), .app_type(cmd_type),
    .mv_en(mv_en), .mv_idx(mv_idx), .drop_en(drop_en),
    .slot_addr(slot_addr), .slot_type(slot_type),
    .slot_live(slot_live), .count(count)
  );

  bkpt_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .USE_TYPE(1'b1)) u_del_match (
    .key_addr(cmd_addr), .key_type(cmd_type),
    .slot_addr(slot_addr), .slot_type(slot_type), .slot_live(slot_live),
    .hit(del_hit), .hit_idx(del_idx)
  );

  bkpt_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .USE_TYPE(1'b0)) u_look_match (
    .key_addr(fetch_addr), .key_type(TYPE_NONE),
    .slot_addr(slot_addr), .slot_type(slot_type), .slot_live(slot_live),
    .hit(look_hit), .hit_idx(look_idx)
  );

  assign fetch_type = look_hit ? slot_type[look_idx] : TYPE_NONE;

  bkpt_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_type(cmd_type),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .inval_valid(inval_valid), .inval_addr(inval_addr),
    .count(count), .del_hit(del_hit), .del_idx(del_idx),
    .app_en(app_en), .mv_en(mv_en), .mv_idx(mv_idx), .drop_en(drop_en)
  );

  AST_LOOKUP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |-> fetch_type == TYPE_NONE); // R8

endmodule

// File: tb/bkpt_table_bench.sv
module bkpt_table_bench;
  localparam int DEPTH = 8;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid, cmd_op, rsp_ready;
  logic [AW-1:0] cmd_addr, fetch_addr;
  logic [1:0]    cmd_type;
  logic          cmd_ready, rsp_valid, rsp_ok, inval_valid;
  logic [1:0]    fetch_type;
  logic [AW-1:0] inval_addr;

  always #10 clk = ~clk;

  bkpt_table #(.DEPTH(DEPTH), .ADDR_W(AW)) u_bkpt_table (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_type(cmd_type),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ok(rsp_ok),
    .fetch_addr(fetch_addr), .fetch_type(fetch_type),
    .inval_valid(inval_valid), .inval_addr(inval_addr)
  );

  int n_pass = 0;
  int n_fail = 0;

  task automatic chk(input bit good, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    if (good) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model of the table
  logic [AW-1:0] m_addr [DEPTH];
  logic [1:0]    m_type [DEPTH];
  int            m_cnt = 0;

  // Scoreboard queues
  bit            exp_ok_q  [$];
  string         exp_req_q [$];
  logic [AW-1:0] exp_inv_q [$];

  function automatic logic [1:0] model_look(input logic [AW-1:0] a);
    for (int i = m_cnt - 1; i >= 0; i--) begin
      if (m_addr[i] == a) model_look = m_type[i];
    end
    for (int i = 0; i < m_cnt; i++) begin
      if (m_addr[i] == a) return m_type[i];
    end
    return 2'd0;
  endfunction

  // Driver: compute expectation, push it, then drive the command.
  task automatic send(input bit op, input logic [AW-1:0] a, input logic [1:0] t,
                      input string req);
    bit ok = 1'b0;
    int lat_exp = 1;
    int lat;
    int k = -1;
    if (op == 1'b0) begin
      ok = (m_cnt < DEPTH) && (t != 2'd0);
      if (ok) begin
        m_addr[m_cnt] = a;
        m_type[m_cnt] = t;
        m_cnt++;
      end
    end else begin
      for (int i = m_cnt - 1; i >= 0; i--) begin
        if (m_addr[i] == a && m_type[i] == t) k = i;
      end
      ok = (k >= 0);
      if (ok) begin
        lat_exp = m_cnt - k;
        for (int i = k; i < m_cnt - 1; i++) begin
          m_addr[i] = m_addr[i + 1];
          m_type[i] = m_type[i + 1];
        end
        m_cnt--;
      end
    end
    exp_ok_q.push_back(ok);
    exp_req_q.push_back(req);
    if (ok) exp_inv_q.push_back(a);

    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_type = t;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == lat_exp, $sformatf("%s/R7 latency", req), lat, lat_exp);
    chk(!cmd_ready, "R10 not ready with response", cmd_ready, 0);
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic look(input logic [AW-1:0] a, input string req);
    logic [1:0] e;
    @(negedge clk);
    fetch_addr = a;
    #1;
    e = model_look(a);
    chk(fetch_type == e, $sformatf("%s/R8 lookup %0h", req, a), fetch_type, e);
  endtask

  // Monitor: back-pressure, response and invalidate scoreboard
  logic [7:0] lfsr = 8'hA5;
  bit prev_hold = 0, prev_ok = 0, prev_inv = 0, prev_rv = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready = lfsr[0] | lfsr[2];
      if (prev_hold)
        chk(rsp_valid && rsp_ok == prev_ok, "R10 hold under stall",
            {rsp_valid, rsp_ok}, {1'b1, prev_ok});
      if (inval_valid) begin
        chk(!prev_inv, "R9 strobe single cycle", prev_inv, 0);
        chk(rsp_valid && !prev_rv, "R9 strobe with first response cycle",
            {rsp_valid, prev_rv}, 2'b10);
        if (exp_inv_q.size() == 0)
          chk(1'b0, "R9 unexpected strobe", inval_addr, 0);
        else begin
          logic [AW-1:0] ea;
          ea = exp_inv_q.pop_front();
          chk(inval_addr == ea, "R9 strobe address", inval_addr, ea);
        end
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_ok_q.size() == 0)
          chk(1'b0, "R10 unexpected response", rsp_ok, 0);
        else begin
          bit eo;
          string rq;
          eo = exp_ok_q.pop_front();
          rq = exp_req_q.pop_front();
          chk(rsp_ok == eo, $sformatf("%s response ok", rq), rsp_ok, eo);
        end
      end
      prev_hold = rsp_valid && !rsp_ready;
      prev_ok   = rsp_ok;
      prev_inv  = inval_valid;
      prev_rv   = rsp_valid;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 1'b0; cmd_addr = '0;
    cmd_type = '0; rsp_ready = 1'b0; fetch_addr = 32'h100;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
    chk(inval_valid == 1'b0, "R1 no strobe after reset", inval_valid, 0);
    chk(fetch_type == 2'd0, "R1 empty lookup", fetch_type, 0);

    send(1'b0, 32'h100, 2'd1, "R2");
    send(1'b0, 32'h104, 2'd2, "R2");
    send(1'b0, 32'h100, 2'd3, "R2");
    send(1'b0, 32'h108, 2'd1, "R2");
    look(32'h100, "R8");
    look(32'h104, "R8");
    look(32'h200, "R8");

    send(1'b0, 32'h10C, 2'd0, "R4");
    look(32'h10C, "R4");

    send(1'b1, 32'h100, 2'd2, "R5");
    look(32'h100, "R5");
    send(1'b1, 32'h300, 2'd1, "R5");

    send(1'b1, 32'h100, 2'd1, "R6");
    look(32'h100, "R6");
    look(32'h108, "R6");

    for (int i = 0; i < 5; i++)
      send(1'b0, 32'h200 + 32'(4 * i), 2'((i % 3) + 1), "R2");
    send(1'b0, 32'h400, 2'd1, "R3");
    look(32'h400, "R3");
    look(32'h20C, "R8");

    send(1'b1, 32'h210, 2'd2, "R7");
    send(1'b1, 32'h104, 2'd2, "R7");
    look(32'h104, "R7");

    while (m_cnt > 0)
      send(1'b1, m_addr[m_cnt / 2], m_type[m_cnt / 2], "R6");
    look(32'h100, "R6");
    look(32'h204, "R6");

    for (int i = 0; i < DEPTH; i++)
      send(1'b0, 32'h800 + 32'(i), 2'((i % 3) + 1), "R2");
    send(1'b0, 32'h900, 2'd2, "R3");
    look(32'h807, "R3");

    repeat (4) @(negedge clk);
    chk(exp_ok_q.size() == 0, "R10 all responses seen", exp_ok_q.size(), 0);
    chk(exp_inv_q.size() == 0, "R9 all strobes seen", exp_inv_q.size(), 0);
    finish_run();
  end
endmodule